// File: doc/BRIEF.md
# Dual-Mode Processor Timer

This block is a timer owned by one processor. It has two personalities, and a mode bit from an external mode register picks between them. In counter mode it is a periodic limit timer. A count rises by 0x200 on each 500 ns tick and returns to zero when it reaches the programmed limit. At that point it sets a reached flag and raises the interrupt to the local processor.

In user mode the same register window exposes a 63-bit up-counter. There is no limit and no interrupt. Software reads and loads the counter as an upper half and a lower half, and starts or stops it through a control bit. Changing the mode bit forces the run state and clears the count.

The register port is word addressed with a 2-bit slot index:
- slot 0 holds the limit or the upper half.
- slot 1 holds the count or the lower half.
- slot 2 sets the limit without a restart.
- slot 3 is control and status.

Read data is registered and is valid one cycle after the read strobe.

Top module: `ptmr_dual_timer`

## Requirements
- R1: After reset the block is in counter mode with limit 0, count 0, irq low and running set, so a slot 3 read returns 1.
- R2: In counter mode a slot 0 write takes data bits 30..9 as the limit, clears the count, the reached flag and irq. A slot 0 read returns the limit with bits 31 and 8..0 zero.
- R3: In counter mode each tick adds 0x200 to the count. A slot 1 read returns the reached flag in bit 31 and the count in bits 30..0. A tick that would bring the count to a nonzero limit returns the count to 0 and sets the reached flag and irq, both visible the cycle after that tick.
- R4: With limit 0 the counter free-runs and never sets the reached flag or irq.
- R5: In counter mode a slot 0 read clears the reached flag and irq. If a limit hit falls in the same cycle, the hit wins and both stay set.
- R6: In counter mode a slot 2 write sets the limit from data bits 30..9 without touching the count or the reached flag.
- R7: In counter mode, writes to slot 1 and slot 3 have no effect. A slot 3 read returns the running flag in bit 0 in either mode.
- R8: When the mode bit goes from 0 to 1, irq falls, running clears, and the count and the reached flag become 0.
- R9: In user mode a slot 3 write with bit 0 = 1 starts the counter and one with bit 0 = 0 stops it. A stopped counter holds its value, and a write that matches the current state changes nothing.
- R10: In user mode the 63-bit count rises by 0x200 per tick while running. A slot 0 read returns the reached flag in bit 31 and count bits 62..32 in bits 30..0. A slot 1 read returns count bits 31..0, whose bits 8..0 are always zero.
- R11: In user mode a slot 0 write loads count bits 62..32 from data bits 30..0, and a slot 1 write loads count bits 31..9 from data bits 31..9. Either write clears the reached flag, and a load in the same cycle as a tick takes the loaded value with no increment.
- R12: In user mode a tick at the count 0x7FFFFFFFFFFFFE00 wraps it to 0 and sets the reached flag with irq staying low. irq is never high in user mode.
- R13: When the mode bit goes from 1 to 0, running sets and the count and the reached flag become 0. In the cycle where the mode bit differs from its registered copy, register writes, read side effects and ticks are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse every 500 ns |
| user_mode | input | 1 | 1 selects user counter, 0 selects limit timer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word slot index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt to the local processor |

## Verification
Two pairs of actions can land in the same cycle and are provoked on purpose.

- A tick that hits the limit is issued in the same cycle as a slot 0 read that would clear the flag. The flag and irq must survive, and the read must still return the limit.
- A user-mode lower-half load is issued together with a tick while the counter runs. The slot 1 read that follows must show exactly the loaded value, with no added 0x200.

A mode change issued with a write and a tick is judged the same way: the limit must read back unchanged and the count must be zero.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [1:0] {
    SLOT_LIMIT    = 2'd0,
    SLOT_COUNT    = 2'd1,
    SLOT_LIMIT_NR = 2'd2,
    SLOT_CTRL     = 2'd3
  } slot_e;

  typedef struct packed {
    logic lim_rst;   // counter mode: limit + restart
    logic lim_keep;  // counter mode: limit only
    logic hi_ld;     // user mode: upper half load
    logic lo_ld;     // user mode: lower half load
    logic ctl;       // user mode: run/stop
  } wr_req_t;

endpackage

// File: rtl/ptmr_mode_ctl.sv
module ptmr_mode_ctl (
  input  logic clk,
  input  logic rst,
  input  logic user_mode,
  input  logic ctl_wr,
  input  logic ctl_bit,
  output logic mode_q,
  output logic chg,
  output logic run_q
);

  assign chg = user_mode ^ mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      run_q  <= 1'b1;
    end else if (chg) begin
      mode_q <= user_mode;
      run_q  <= ~user_mode;
    end else if (ctl_wr) begin
      run_q  <= ctl_bit;
    end
  end

  // R1 R13
  run_cnt_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> run_q);

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_q,
  input  logic                     chg,
  input  logic                     run_q,
  input  logic                     tick,
  input  wr_req_t                  wr,
  input  logic                     lim_rd_clr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W+DATA_W-FRAC_W-2:0] tk_q,
  output logic [DATA_W-FRAC_W-2:0] lim_q,
  output logic                     reached_q,
  output logic                     hit
);

  localparam int HI_W    = DATA_W - 1;
  localparam int LO_TK_W = DATA_W - FRAC_W;
  localparam int TK_W    = HI_W + LO_TK_W;
  localparam int LTK_W   = DATA_W - 1 - FRAC_W;

  logic [TK_W-1:0]  tk_d;
  logic [LTK_W-1:0] lim_d;
  logic [LTK_W-1:0] lim_eff;
  logic [LTK_W:0]   cnt_nxt;
  logic             rch_d;

  always_comb begin
    tk_d    = tk_q;
    lim_d   = lim_q;
    rch_d   = reached_q;
    hit     = 1'b0;
    lim_eff = (lim_q == '0) ? '1 : lim_q;
    cnt_nxt = {1'b0, tk_q[LTK_W-1:0]} + 1'b1;
    if (chg) begin
      tk_d  = '0;
      rch_d = 1'b0;
    end else if (!mode_q) begin
      if (wr.lim_rst) begin
        lim_d = wdata[DATA_W-2:FRAC_W];
        tk_d  = '0;
        rch_d = 1'b0;
      end else begin
        if (wr.lim_keep) lim_d = wdata[DATA_W-2:FRAC_W];
        if (lim_rd_clr)  rch_d = 1'b0;
        if (tick) begin
          if (cnt_nxt >= {1'b0, lim_eff}) begin
            tk_d = '0;
            if (lim_q != '0) begin
              hit   = 1'b1;
              rch_d = 1'b1;
            end
          end else begin
            tk_d = TK_W'(cnt_nxt);
          end
        end
      end
    end else begin
      if (wr.hi_ld) begin
        tk_d[TK_W-1:LO_TK_W] = wdata[HI_W-1:0];
        rch_d = 1'b0;
      end else if (wr.lo_ld) begin
        tk_d[LO_TK_W-1:0] = wdata[DATA_W-1:FRAC_W];
        rch_d = 1'b0;
      end else if (tick && run_q) begin
        if (&tk_q) begin
          tk_d  = '0;
          rch_d = 1'b1;
        end else begin
          tk_d = tk_q + TK_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tk_q      <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
    end else begin
      tk_q      <= tk_d;
      lim_q     <= lim_d;
      reached_q <= rch_d;
    end
  end

  // R3
  hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (reached_q && tk_q == '0));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !run_q && !chg && !wr.hi_ld && !wr.lo_ld) |=> $stable(tk_q));

endmodule

// File: rtl/ptmr_rd_mux.sv
module ptmr_rd_mux
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd,
  input  slot_e                    slot,
  input  logic                     mode_q,
  input  logic                     run_q,
  input  logic                     reached_q,
  input  logic [DATA_W+DATA_W-FRAC_W-2:0] tk_q,
  input  logic [DATA_W-FRAC_W-2:0] lim_q,
  output logic [DATA_W-1:0]        rdata
);

  localparam int LO_TK_W = DATA_W - FRAC_W;
  localparam int TK_W    = DATA_W - 1 + LO_TK_W;
  localparam int LTK_W   = DATA_W - 1 - FRAC_W;

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    unique case (slot)
      SLOT_LIMIT: rd_d = mode_q ? {reached_q, tk_q[TK_W-1:LO_TK_W]}
                                : {1'b0, lim_q, {FRAC_W{1'b0}}};
      SLOT_COUNT: rd_d = mode_q ? {tk_q[LO_TK_W-1:0], {FRAC_W{1'b0}}}
                                : {reached_q, tk_q[LTK_W-1:0], {FRAC_W{1'b0}}};
      SLOT_CTRL:  rd_d = {{(DATA_W-1){1'b0}}, run_q};
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_d;
  end

endmodule

// File: rtl/ptmr_dual_timer.sv
module ptmr_dual_timer
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              user_mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int LO_TK_W = DATA_W - FRAC_W;
  localparam int TK_W    = DATA_W - 1 + LO_TK_W;
  localparam int LTK_W   = DATA_W - 1 - FRAC_W;

  logic             mode_q, chg, run_q, reached_q, hit, lim_rd_clr, acc_ok;
  logic [TK_W-1:0]  tk_q;
  logic [LTK_W-1:0] lim_q;
  wr_req_t          wr;
  slot_e            slot;

  assign slot   = slot_e'(reg_addr);
  assign acc_ok = !chg;

  always_comb begin
    wr.lim_rst  = reg_wr && acc_ok && !mode_q && slot == SLOT_LIMIT;
    wr.lim_keep = reg_wr && acc_ok && !mode_q && slot == SLOT_LIMIT_NR;
    wr.hi_ld    = reg_wr && acc_ok &&  mode_q && slot == SLOT_LIMIT;
    wr.lo_ld    = reg_wr && acc_ok &&  mode_q && slot == SLOT_COUNT;
    wr.ctl      = reg_wr && acc_ok &&  mode_q && slot == SLOT_CTRL;
  end
  assign lim_rd_clr = reg_rd && acc_ok && !mode_q && slot == SLOT_LIMIT;

  ptmr_mode_ctl u_mode (
    .clk(clk), .rst(rst), .user_mode(user_mode),
    .ctl_wr(wr.ctl), .ctl_bit(reg_wdata[0]),
    .mode_q(mode_q), .chg(chg), .run_q(run_q)
  );

  ptmr_count #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_count (
    .clk(clk), .rst(rst), .mode_q(mode_q), .chg(chg), .run_q(run_q),
    .tick(tick), .wr(wr), .lim_rd_clr(lim_rd_clr), .wdata(reg_wdata),
    .tk_q(tk_q), .lim_q(lim_q), .reached_q(reached_q), .hit(hit)
  );

  ptmr_rd_mux #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_rd (
    .clk(clk), .rst(rst), .rd(reg_rd), .slot(slot), .mode_q(mode_q),
    .run_q(run_q), .reached_q(reached_q), .tk_q(tk_q), .lim_q(lim_q),
    .rdata(reg_rdata)
  );

  // hit beats the read clear; a limit write never coincides with a hit
  always_ff @(posedge clk) begin
    if (rst)                          irq <= 1'b0;
    else if (chg)                     irq <= 1'b0;
    else if (hit)                     irq <= 1'b1;
    else if (wr.lim_rst || lim_rd_clr) irq <= 1'b0;
  end

  // R12
  irq_user_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> !irq);

  // R8
  enter_user_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q) |-> (!run_q && tk_q == '0 && !reached_q));

  // R13
  enter_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_q) |-> (run_q && tk_q == '0 && !irq));

endmodule

// File: tb/tb_ptmr_dual_timer.sv
module tb_ptmr_dual_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, user_mode = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ptmr_dual_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .user_mode(user_mode),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // row: op[68:67] (0 rd,1 wr,2 tick) slot[66:65] data[64:33] exp[32:1] irq[0]
  localparam int NV = 32;
  localparam logic [68:0] TBL [NV] = '{
    {2'd0, 2'd3, 32'h0,        32'h1,        1'b0}, // R1 running
    {2'd0, 2'd0, 32'h0,        32'h0,        1'b0}, // R1 limit
    {2'd0, 2'd1, 32'h0,        32'h0,        1'b0}, // R1 count
    {2'd1, 2'd0, 32'h80000BFF, 32'h0,        1'b0}, // R2 masked limit
    {2'd0, 2'd0, 32'h0,        32'h00000A00, 1'b0}, // R2
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0}, // R3
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd0, 2'd1, 32'h0,        32'h00000600, 1'b0}, // R3
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b1}, // R3 hit
    {2'd0, 2'd1, 32'h0,        32'h80000000, 1'b1}, // R3
    {2'd0, 2'd0, 32'h0,        32'h00000A00, 1'b0}, // R5 clear
    {2'd0, 2'd1, 32'h0,        32'h0,        1'b0}, // R5
    {2'd1, 2'd3, 32'h0,        32'h0,        1'b0}, // R7
    {2'd0, 2'd3, 32'h0,        32'h1,        1'b0}, // R7
    {2'd1, 2'd1, 32'h12345600, 32'h0,        1'b0}, // R7
    {2'd0, 2'd1, 32'h0,        32'h0,        1'b0}, // R7
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd1, 2'd2, 32'h00001000, 32'h0,        1'b0}, // R6
    {2'd0, 2'd1, 32'h0,        32'h00000400, 1'b0}, // R6
    {2'd0, 2'd0, 32'h0,        32'h00001000, 1'b0}, // R6
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b0},
    {2'd0, 2'd1, 32'h0,        32'h00000E00, 1'b0}, // R6
    {2'd2, 2'd0, 32'h0,        32'h0,        1'b1}, // R6 hit
    {2'd0, 2'd1, 32'h0,        32'h80000000, 1'b1}, // R6
    {2'd0, 2'd0, 32'h0,        32'h00001000, 1'b0}  // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic t, input logic m,
                      input logic [1:0] a, input logic [31:0] d);
    reg_wr = w; reg_rd = r; tick = t; user_mode = m; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, 1'b0, user_mode, a, d);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, user_mode, 2'd0, 32'h0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    step(1'b0, 1'b1, 1'b0, user_mode, a, 32'h0);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq at reset", {31'h0, irq}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      step(TBL[v][68:67] == 2'd1, TBL[v][68:67] == 2'd0, TBL[v][68:67] == 2'd2,
           1'b0, TBL[v][66:65], TBL[v][64:33]);
      if (TBL[v][68:67] == 2'd0) chk($sformatf("table row %0d rdata", v), reg_rdata, TBL[v][32:1]);
      chk($sformatf("table row %0d irq", v), {31'h0, irq}, {31'h0, TBL[v][0]});
    end

    // R4 zero limit free-runs, no flag, no irq
    wr(2'd0, 32'h0);
    tk(100);
    chk("R4 irq", {31'h0, irq}, 32'h0);
    rd(2'd1, 32'h0000C800, "R4 count");

    // R5 hit and limit read in one cycle: hit wins
    wr(2'd0, 32'h00000400);
    tk(1);
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0);
    chk("R5 collide rdata", reg_rdata, 32'h00000400);
    chk("R5 collide irq", {31'h0, irq}, 32'h1);
    rd(2'd1, 32'h80000000, "R5 flag kept");

    // R8 switch to user mode
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0);
    chk("R8 irq low", {31'h0, irq}, 32'h0);
    rd(2'd3, 32'h0, "R8 stopped");
    rd(2'd1, 32'h0, "R8 lo zero");
    rd(2'd0, 32'h0, "R8 hi zero");

    // R9 start / stop
    wr(2'd3, 32'h1);
    tk(3);
    rd(2'd1, 32'h00000600, "R9 running count");
    rd(2'd3, 32'h1, "R9 running flag");
    wr(2'd3, 32'h0);
    tk(2);
    rd(2'd1, 32'h00000600, "R9 stopped hold");
    wr(2'd3, 32'h0);
    rd(2'd3, 32'h0, "R9 matching stop");
    wr(2'd3, 32'h1);
    wr(2'd3, 32'h1);
    tk(1);
    rd(2'd1, 32'h00000800, "R9 restart");

    // R11 half loads, load beats tick
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, 32'h7FFFFFFF, "R11 hi load");
    wr(2'd1, 32'h123456FF);
    rd(2'd1, 32'h12345600, "R11 lo load");
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 32'h00000400);
    rd(2'd1, 32'h00000400, "R11 load beats tick");
    rd(2'd0, 32'h7FFFFFFF, "R11 hi kept");

    // R10 carry from lower to upper half
    wr(2'd0, 32'h5);
    wr(2'd1, 32'hFFFFFE00);
    tk(1);
    rd(2'd0, 32'h00000006, "R10 carry hi");
    rd(2'd1, 32'h0, "R10 carry lo");

    // R12 wrap at maximum
    wr(2'd0, 32'h7FFFFFFF);
    wr(2'd1, 32'hFFFFFE00);
    tk(1);
    chk("R12 no irq", {31'h0, irq}, 32'h0);
    rd(2'd0, 32'h80000000, "R12 wrap flag");
    rd(2'd1, 32'h0, "R12 wrap lo");
    wr(2'd1, 32'h00000200);
    rd(2'd0, 32'h0, "R11 load clears flag");

    // R13 back to counter mode; write and tick in the change cycle dropped
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h00002000);
    rd(2'd3, 32'h1, "R13 running");
    rd(2'd1, 32'h0, "R13 count zero");
    rd(2'd0, 32'h00000400, "R13 limit kept");
    tk(1);
    chk("R13 no irq yet", {31'h0, irq}, 32'h0);
    tk(1);
    chk("R13 hit irq", {31'h0, irq}, 32'h1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule